// File: doc/BRIEF.md
# Time-Division Multi-Stream Link Transmitter

This block shares one narrow point-to-point link among several independent data streams. Each stream delivers 64-bit raw words, already packed and padded upstream, into a small FIFO of its own. The link is divided into word slots. A wrapping slot counter walks a schedule table that is fixed at elaboration. For every slot, the table names the stream that owns it, and at most one word from that stream's FIFO goes out in that slot.

Each raw word crosses the link as four 16-bit beats. The block runs on the link beat clock, so one word slot lasts four clock cycles. Four sideband lines go with the beats. The first marks the start of each word. The second marks the start of slot 0, which opens each schedule cycle. The third says whether the current slot carries real data. The fourth is a back-pressure input from the far end. A slot whose owner has nothing queued, or that falls under back-pressure, goes out empty. It is never lent to another stream, so every stream keeps fixed timing on the link.

Top module: `tdm_link_tx`

## Requirements
- R1: While reset is held and in the cycle it is released, `link_valid` is low, `link_beat` is zero and every `push_ready` bit is high.
- R2: Each slot lasts four clock cycles. Beat n of a word carries bits [16n+15:16n], so the least significant beat goes first. `link_valid` stays constant across all four beats of a slot.
- R3: `link_word_sync` is high on the first beat of every slot and low on the other three beats.
- R4: The slot index advances by one per slot and wraps to 0 after slot N_SLOTS-1. After reset the first slot on the wire is slot 0 and carries no data. `link_cycle_sync` is high exactly on the first beat of slot 0.
- R5: A word sent in slot s comes from stream SCHED[s*ID_W +: ID_W]. With the default table, the owners of slots 0 to 11 are 0,1,0,1,0,2,1,0,1,0,1,2.
- R6: If the owning stream's FIFO is empty when a slot is loaded, the slot is sent with `link_valid` low and all beats zero, and no other stream's FIFO is read.
- R7: `link_stall_in` is sampled on the last beat of the previous slot. When it is high there, the next slot is sent empty (valid low, beats zero) and no FIFO is read.
- R8: Words of each stream leave in the order they were accepted, with none lost and none duplicated.
- R9: `push_ready[i]` is low while stream i holds FIFO_DEPTH words. A push offered in that state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | N_STREAMS | Per-stream write request |
| push_data | input | N_STREAMS*64 | Per-stream raw word; stream i at bits [64i+63:64i] |
| push_ready | output | N_STREAMS | Per-stream FIFO has room |
| link_stall_in | input | 1 | Back-pressure from the receiver |
| link_beat | output | 16 | Current 16-bit beat |
| link_valid | output | 1 | Current slot carries a data word |
| link_word_sync | output | 1 | First beat of a slot |
| link_cycle_sync | output | 1 | First beat of slot 0 |

## Verification
The bench builds the block with its defaults: three streams, a 12-slot table with the uneven 5/5/2 share, and a FIFO depth of four. The shallow FIFOs fill within a few slots under back-pressure, so the full and ignored-push behaviour can be reached quickly. The uneven table leaves two slots per cycle belonging to a stream the bench can starve, which exposes any slot lending. Every word is stamped with its stream and a sequence number, so the interleaving against the table and the absence of loss or duplication are checked from the link beats alone.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

    localparam int unsigned RAW_W          = 64;
    localparam int unsigned BEAT_W         = 16;
    localparam int unsigned BEATS_PER_WORD = RAW_W / BEAT_W;

    typedef logic [RAW_W-1:0]  raw_word_t;
    typedef logic [BEAT_W-1:0] beat_t;

    // Owners of slots 11 down to 0, two bits each (slot 0 in the low bits).
    localparam logic [23:0] DEFAULT_SCHED = {2'd2, 2'd1, 2'd0, 2'd1, 2'd0, 2'd1,
                                             2'd2, 2'd0, 2'd1, 2'd0, 2'd1, 2'd0};

endpackage

// File: rtl/tdm_stream_fifo.sv
module tdm_stream_fifo
    import tdm_link_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  raw_word_t wr_data,
    output logic      wr_ready,
    input  logic      rd_en,
    output raw_word_t rd_data,
    output logic      rd_avail
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][RAW_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        do_wr, do_rd;

    assign wr_ready = (st_q.cnt != CNT_W'(DEPTH));
    assign rd_avail = (st_q.cnt != '0);
    assign rd_data  = st_q.mem[st_q.rd];

    always_comb begin
        st_d  = st_q;
        do_wr = wr_en && wr_ready;
        do_rd = rd_en && rd_avail;
        if (do_wr) begin
            st_d.mem[st_q.wr] = wr_data;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_rd) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter int unsigned N_SLOTS = 12,
    parameter int unsigned ID_W    = 2,
    parameter int unsigned SLOT_W  = 4,
    parameter logic [N_SLOTS*ID_W-1:0] SCHED = '0
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [ID_W-1:0]   owner
);

    always_comb begin
        owner = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (slot == SLOT_W'(s)) owner = SCHED[s*ID_W +: ID_W];
        end
    end

endmodule

// File: rtl/tdm_link_tx.sv
module tdm_link_tx
    import tdm_link_pkg::*;
#(
    parameter int unsigned N_STREAMS  = 3,
    parameter int unsigned N_SLOTS    = 12,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned ID_W       = 2,
    parameter logic [N_SLOTS*ID_W-1:0] SCHED = DEFAULT_SCHED
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_STREAMS-1:0]       push_valid,
    input  logic [N_STREAMS*RAW_W-1:0] push_data,
    output logic [N_STREAMS-1:0]       push_ready,
    input  logic                       link_stall_in,
    output logic [BEAT_W-1:0]          link_beat,
    output logic                       link_valid,
    output logic                       link_word_sync,
    output logic                       link_cycle_sync
);

    localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int unsigned BIDX_W = (BEATS_PER_WORD > 1) ? $clog2(BEATS_PER_WORD) : 1;

    typedef struct packed {
        logic [BIDX_W-1:0] beat;
        logic [SLOT_W-1:0] slot;
        logic              valid;
        raw_word_t         word;
    } tx_state_t;

    tx_state_t            st_d, st_q;
    logic [N_STREAMS-1:0] lane_pop;
    logic [N_STREAMS-1:0] lane_avail;
    raw_word_t            lane_head [N_STREAMS];
    logic [SLOT_W-1:0]    nxt_slot;
    logic [ID_W-1:0]      owner;
    logic                 beat_last;
    logic                 take;

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_lane
        tdm_stream_fifo #(
            .DEPTH(FIFO_DEPTH)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (push_valid[g]),
            .wr_data  (push_data[g*RAW_W +: RAW_W]),
            .wr_ready (push_ready[g]),
            .rd_en    (lane_pop[g]),
            .rd_data  (lane_head[g]),
            .rd_avail (lane_avail[g])
        );
    end

    tdm_slot_table #(
        .N_SLOTS (N_SLOTS),
        .ID_W    (ID_W),
        .SLOT_W  (SLOT_W),
        .SCHED   (SCHED)
    ) u_table (
        .slot  (nxt_slot),
        .owner (owner)
    );

    assign beat_last = (st_q.beat == BIDX_W'(BEATS_PER_WORD - 1));
    assign nxt_slot  = (st_q.slot == SLOT_W'(N_SLOTS - 1)) ? '0 : st_q.slot + 1'b1;

    always_comb begin
        st_d     = st_q;
        lane_pop = '0;
        take     = 1'b0;
        st_d.beat = beat_last ? '0 : st_q.beat + 1'b1;
        if (beat_last) begin
            st_d.slot = nxt_slot;
            if (int'(owner) < N_STREAMS) begin
                take = lane_avail[owner] && !link_stall_in;
            end
            st_d.valid = take;
            st_d.word  = '0;
            if (take) begin
                lane_pop[owner] = 1'b1;
                st_d.word       = lane_head[owner];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_beat       = st_q.word[BEAT_W*int'(st_q.beat) +: BEAT_W];
    assign link_valid      = st_q.valid;
    assign link_word_sync  = (st_q.beat == '0);
    assign link_cycle_sync = (st_q.beat == '0) && (st_q.slot == '0);

endmodule

// File: rtl/tdm_link_tx_chk.sv
module tdm_link_tx_chk
    import tdm_link_pkg::*;
#(
    parameter int unsigned N_SLOTS = 12
) (
    input logic  clk,
    input logic  rst_n,
    input beat_t link_beat,
    input logic  link_valid,
    input logic  link_word_sync,
    input logic  link_cycle_sync
);

    int unsigned words_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_seen <= 0;
        end else if (link_word_sync) begin
            words_seen <= link_cycle_sync ? 1 : words_seen + 1;
        end
    end

    // R3
    word_sync_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_word_sync |=> !link_word_sync);

    // R4
    sync_alignment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_cycle_sync |-> link_word_sync);

    // R4
    cycle_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_word_sync && words_seen != 0) |-> (link_cycle_sync == (words_seen == N_SLOTS)));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> (link_beat == '0));

    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_word_sync |-> $stable(link_valid));

endmodule

bind tdm_link_tx tdm_link_tx_chk #(
    .N_SLOTS(N_SLOTS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_beat       (link_beat),
    .link_valid      (link_valid),
    .link_word_sync  (link_word_sync),
    .link_cycle_sync (link_cycle_sync)
);

// File: tb/tdm_link_tx_test.sv
`timescale 1ns/1ps
module tdm_link_tx_test;
    import tdm_link_pkg::*;

    localparam int NS  = 3;
    localparam int NSL = 12;
    localparam int DEP = 4;

    int sched_ref [NSL] = '{0, 1, 0, 1, 0, 2, 1, 0, 1, 0, 1, 2};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      push_valid = '0;
    logic [NS*64-1:0]   push_data = '0;
    logic [NS-1:0]      push_ready;
    logic               link_stall_in = 1'b0;
    logic [15:0]        link_beat;
    logic               link_valid, link_word_sync, link_cycle_sync;

    always #2 clk = ~clk;

    tdm_link_tx uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_valid      (push_valid),
        .push_data       (push_data),
        .push_ready      (push_ready),
        .link_stall_in   (link_stall_in),
        .link_beat       (link_beat),
        .link_valid      (link_valid),
        .link_word_sync  (link_word_sync),
        .link_cycle_sync (link_cycle_sync)
    );

    int checks = 0, errors = 0;

    // reference model state
    int          m_beat = 0, m_slot = 0;
    bit          m_valid = 0;
    logic [63:0] m_word = '0;
    logic [63:0] mq [NS][$];
    int          tx_seq [NS] = '{0, 0, 0};
    int          rx_seq [NS] = '{0, 0, 0};

    // link-side scoreboard
    int          sb_idx = 0, sb_slot = 0;
    logic [63:0] sb_word = '0;
    bit          r6_on = 0, r7_on = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic [NS-1:0] pv, input logic stl);
        bit          acc [NS];
        logic [63:0] wd  [NS];
        logic [15:0] exp_beat;
        logic [NS-1:0] exp_rdy;
        int          o;
        for (int i = 0; i < NS; i++) begin
            wd[i] = {8'(i), 24'h0, 32'(tx_seq[i])};
            push_data[i*64 +: 64] = wd[i];
            acc[i] = pv[i] && (mq[i].size() < DEP);
        end
        push_valid    = pv;
        link_stall_in = stl;
        if (m_beat == 3) begin
            m_beat = 0;
            m_slot = (m_slot + 1) % NSL;
            o = sched_ref[m_slot];
            if (mq[o].size() > 0 && !stl) begin
                m_word  = mq[o].pop_front();
                m_valid = 1;
            end else begin
                m_word  = '0;
                m_valid = 0;
            end
        end else begin
            m_beat++;
        end
        for (int i = 0; i < NS; i++) begin
            if (acc[i]) begin
                mq[i].push_back(wd[i]);
                tx_seq[i]++;
            end
        end
        @(negedge clk);
        exp_beat = m_word[16*m_beat +: 16];
        for (int i = 0; i < NS; i++) exp_rdy[i] = (mq[i].size() < DEP);
        // R2 beat order and valid; R6/R7 idle slots follow from the model
        check(link_beat === exp_beat && link_valid === m_valid, "R2", "beat/valid",
              {47'd0, link_valid, link_beat}, {47'd0, m_valid, exp_beat});
        check(link_word_sync === (m_beat == 0), "R3", "word_sync",
              64'(link_word_sync), 64'(m_beat == 0));
        check(link_cycle_sync === (m_beat == 0 && m_slot == 0), "R4", "cycle_sync",
              64'(link_cycle_sync), 64'(m_beat == 0 && m_slot == 0));
        check(push_ready === exp_rdy, "R9", "push_ready", 64'(push_ready), 64'(exp_rdy));
        // scoreboard
        if (link_word_sync) begin
            sb_idx  = 0;
            sb_slot = link_cycle_sync ? 0 : sb_slot + 1;
            if (r6_on && (sb_slot == 5 || sb_slot == 11))
                check(!link_valid, "R6", "empty-owner slot lent", 64'(link_valid), 64'd0);
            if (r7_on)
                check(!link_valid, "R7", "valid under back-pressure", 64'(link_valid), 64'd0);
        end
        if (link_valid && sb_idx < 4) sb_word[16*sb_idx +: 16] = link_beat;
        if (link_valid && sb_idx == 3) begin
            o = int'(sb_word[63:56]);
            check(sb_slot < NSL && o == sched_ref[sb_slot % NSL], "R5", "slot owner",
                  64'(o), 64'(sched_ref[sb_slot % NSL]));
            if (o < NS) begin
                check(sb_word[31:0] == 32'(rx_seq[o]), "R8", "sequence",
                      64'(sb_word[31:0]), 64'(rx_seq[o]));
                rx_seq[o]++;
            end
        end
        sb_idx++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(link_valid === 1'b0 && link_beat === 16'h0 && push_ready === '1, "R1",
              "reset outputs", {link_valid, push_ready, link_beat}, {1'b0, 3'b111, 16'h0});
        rst_n = 1'b1;
        repeat (200) tick('1, 1'b0);
        repeat (400) tick(3'($urandom), ($urandom % 10) < 3);
        repeat (150) tick('0, 1'b0);
        r6_on = 1;
        repeat (200) tick(3'b011, 1'b0);
        r6_on = 0;
        repeat (8) tick('1, 1'b1);
        r7_on = 1;
        repeat (60) tick('1, 1'b1);
        r7_on = 0;
        // R9 every FIFO full after pushing under stall
        check(push_ready === '0, "R9", "full FIFOs", 64'(push_ready), 64'd0);
        repeat (400) tick('0, 1'b0);
        for (int i = 0; i < NS; i++)
            check(rx_seq[i] == tx_seq[i], "R8", "words delivered", 64'(rx_seq[i]), 64'(tx_seq[i]));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule